// File: doc/BRIEF.md
# Byte-Lane Bidirectional Latching Transceiver

The block passes 16-bit data between two buses, A and B, without inverting it. Each direction has its own bank of byte-wide storage. A-to-B storage loads from bus A and feeds bus B. B-to-A storage loads from bus B and feeds bus A. Every byte lane of every direction has three active-low controls: an enable, a latch-enable and an output-enable. Tying the two bytes' controls together gives plain 16-bit operation.

Each bus is split into an input value, an output value and a per-byte drive request, so the tri-state pads stay outside the synthesizable core. A lane's storage is open while its enable and latch-enable are both low. While it is open, the lane's output follows the input in the same cycle. At every clock edge where the lane is open, the storage takes in the input. When the lane closes, the output shows the stored value.

A byte drives its destination bus only when that direction's enable and output-enable are both low. If both directions drive the same byte at once, a per-byte flag reports the contention.

Top module: `byte_latch_xcvr`

## Requirements
- R1: After a synchronous reset with all enables held high, both storage banks hold zero. `a_out` and `b_out` then read 0x0000, and `a_oe`, `b_oe` and `contention` read 0.
- R2: A byte lane of the A-to-B direction is open while its `en_ab_n` bit and its `le_ab_n` bit are both 0. While it is open, that byte of `b_out` equals that byte of `a_in` in the same cycle.
- R3: A lane can close because `le_ab_n` goes to 1. It then holds the `a_in` byte from the last clock edge at which it was open, and later changes on `a_in` do not reach `b_out`.
- R4: While an `en_ab_n` bit is 1, that byte of `b_out` holds its value whatever the level of `le_ab_n`, and that bit of `b_oe` is 0.
- R5: Bit k of `b_oe` is 1 exactly when bit k of `en_ab_n` and bit k of `oe_ab_n` are both 0. Bit 0 controls bits 7:0 and bit 1 controls bits 15:8.
- R6: The B-to-A direction follows R2 to R5 with `en_ba_n`, `le_ba_n` and `oe_ba_n`. It loads from `b_in` and presents on `a_out` and `a_oe`.
- R7: The controls of each byte lane act only on that byte. One byte can be transparent while the other holds.
- R8: The path does not invert: every bit of an output equals the same bit of the stored or passed-through input.
- R9: Bit k of `contention` is 1 exactly when bit k of `a_oe` and bit k of `b_oe` are both 1.
- R10: Each direction's storage is separate. Loading or passing data in one direction leaves the other direction's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which open lanes capture their input |
| rst | input | 1 | Synchronous active-high reset that clears both banks |
| a_in | input | 16 | Value currently seen on bus A |
| b_in | input | 16 | Value currently seen on bus B |
| en_ab_n | input | 2 | Per-byte active-low enable, A to B |
| le_ab_n | input | 2 | Per-byte active-low latch-enable, A to B |
| oe_ab_n | input | 2 | Per-byte active-low output-enable, A to B |
| en_ba_n | input | 2 | Per-byte active-low enable, B to A |
| le_ba_n | input | 2 | Per-byte active-low latch-enable, B to A |
| oe_ba_n | input | 2 | Per-byte active-low output-enable, B to A |
| a_out | output | 16 | Value to drive onto bus A |
| a_oe | output | 2 | Per-byte drive request for bus A |
| b_out | output | 16 | Value to drive onto bus B |
| b_oe | output | 2 | Per-byte drive request for bus B |
| contention | output | 2 | Per-byte flag: both directions drive that byte |

## Verification
Two situations are made to occur in the same cycle.

The first is transparency in one byte and hold in the other. The bench drives a control pattern that opens byte 0 and closes byte 1, changes `a_in`, and checks that `b_out` holds a mixed word. Byte 1 must hold its stored value and byte 0 must show the new input.

The second is both directions driving the same byte. The bench enables the B-to-A outputs while the A-to-B outputs are still on. It then checks that `contention` follows the overlap of `a_oe` and `b_oe`, and that B-to-A loading leaves `b_out` unchanged.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef struct packed {
        logic en_n;
        logic le_n;
        logic oe_n;
    } lane_ctrl_t;

    function automatic logic gate_open(lane_ctrl_t c);
        return !c.en_n && !c.le_n;
    endfunction

    function automatic logic drive_on(lane_ctrl_t c);
        return !c.en_n && !c.oe_n;
    endfunction

endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctrl_t   ctrl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         oe
);
    logic [W-1:0] held;
    logic         open_now;

    assign open_now = gate_open(ctrl);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (open_now) begin
            held <= din;
        end
    end

    // open lanes pass the input through; closed lanes show stored data
    assign dout = open_now ? din : held;
    assign oe   = drive_on(ctrl);
endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
    import xcvr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  en_n,
    input  logic [LANES-1:0]  le_n,
    input  logic [LANES-1:0]  oe_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [LANES-1:0]  oe
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        lane_ctrl_t c;
        assign c.en_n = en_n[k];
        assign c.le_n = le_n[k];
        assign c.oe_n = oe_n[k];

        xcvr_lane #(.W(LANE_W)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .ctrl (c),
            .din  (din[k*LANE_W +: LANE_W]),
            .dout (dout[k*LANE_W +: LANE_W]),
            .oe   (oe[k])
        );
    end
endmodule

// File: rtl/xcvr_contend.sv
module xcvr_contend #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] a_drive,
    input  logic [LANES-1:0] b_drive,
    output logic [LANES-1:0] clash
);
    for (genvar k = 0; k < LANES; k++) begin : g_clash
        assign clash[k] = a_drive[k] & b_drive[k];
    end
endmodule

// File: rtl/byte_latch_xcvr.sv
module byte_latch_xcvr #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [LANES-1:0]  en_ab_n,
    input  logic [LANES-1:0]  le_ab_n,
    input  logic [LANES-1:0]  oe_ab_n,
    input  logic [LANES-1:0]  en_ba_n,
    input  logic [LANES-1:0]  le_ba_n,
    input  logic [LANES-1:0]  oe_ba_n,
    output logic [DATA_W-1:0] a_out,
    output logic [LANES-1:0]  a_oe,
    output logic [DATA_W-1:0] b_out,
    output logic [LANES-1:0]  b_oe,
    output logic [LANES-1:0]  contention
);
    xcvr_dir #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ab (
        .clk  (clk),
        .rst  (rst),
        .en_n (en_ab_n),
        .le_n (le_ab_n),
        .oe_n (oe_ab_n),
        .din  (a_in),
        .dout (b_out),
        .oe   (b_oe)
    );

    xcvr_dir #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ba (
        .clk  (clk),
        .rst  (rst),
        .en_n (en_ba_n),
        .le_n (le_ba_n),
        .oe_n (oe_ba_n),
        .din  (b_in),
        .dout (a_out),
        .oe   (a_oe)
    );

    xcvr_contend #(.LANES(LANES)) u_clash (
        .a_drive (a_oe),
        .b_drive (b_oe),
        .clash   (contention)
    );
endmodule

// File: rtl/byte_latch_xcvr_chk.sv
module byte_latch_xcvr_chk #(
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    localparam int LANES = DATA_W / LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] b_in,
    input logic [LANES-1:0]  en_ab_n,
    input logic [LANES-1:0]  le_ab_n,
    input logic [LANES-1:0]  en_ba_n,
    input logic [LANES-1:0]  le_ba_n,
    input logic [DATA_W-1:0] a_out,
    input logic [LANES-1:0]  a_oe,
    input logic [DATA_W-1:0] b_out,
    input logic [LANES-1:0]  b_oe,
    input logic [LANES-1:0]  contention
);
    for (genvar k = 0; k < LANES; k++) begin : g_chk
        logic shut_ab, shut_ba;
        assign shut_ab = en_ab_n[k] | le_ab_n[k];
        assign shut_ba = en_ba_n[k] | le_ba_n[k];

        AST_PASS_AB: assert property (@(posedge clk) disable iff (rst)
            !shut_ab |-> b_out[k*LANE_W +: LANE_W] == a_in[k*LANE_W +: LANE_W]); // R2

        AST_HOLD_AB: assert property (@(posedge clk) disable iff (rst)
            (shut_ab && $past(shut_ab) && $past(!rst)) |-> $stable(b_out[k*LANE_W +: LANE_W])); // R3

        AST_QUIET_AB: assert property (@(posedge clk) disable iff (rst)
            en_ab_n[k] |-> !b_oe[k]); // R4

        AST_HOLD_BA: assert property (@(posedge clk) disable iff (rst)
            (shut_ba && $past(shut_ba) && $past(!rst)) |-> $stable(a_out[k*LANE_W +: LANE_W])); // R6

        AST_CLASH_CAUSE: assert property (@(posedge clk) disable iff (rst)
            contention[k] |-> (!en_ab_n[k] && !en_ba_n[k])); // R9
    end
endmodule

bind byte_latch_xcvr byte_latch_xcvr_chk #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_in       (a_in),
    .b_in       (b_in),
    .en_ab_n    (en_ab_n),
    .le_ab_n    (le_ab_n),
    .en_ba_n    (en_ba_n),
    .le_ba_n    (le_ba_n),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .contention (contention)
);

// File: tb/byte_latch_xcvr_bench.sv
module byte_latch_xcvr_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] a_in = '0, b_in = '0;
    logic [1:0]  en_ab_n = 2'b11, le_ab_n = 2'b11, oe_ab_n = 2'b11;
    logic [1:0]  en_ba_n = 2'b11, le_ba_n = 2'b11, oe_ba_n = 2'b11;
    logic [15:0] a_out, b_out;
    logic [1:0]  a_oe, b_oe, contention;

    int total = 0;
    int failed = 0;

    always #2.5 clk = ~clk;

    byte_latch_xcvr u_byte_latch_xcvr (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .en_ab_n(en_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
        .en_ba_n(en_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe),
        .contention(contention)
    );

    // {en_ab_n, le_ab_n, oe_ab_n, a_in, expected b_out, expected b_oe}
    localparam logic [39:0] VEC [8] = '{
        {2'b00, 2'b00, 2'b00, 16'h1234, 16'h1234, 2'b11},
        {2'b00, 2'b11, 2'b00, 16'hABCD, 16'h1234, 2'b11},
        {2'b00, 2'b00, 2'b11, 16'h5A5A, 16'h5A5A, 2'b00},
        {2'b11, 2'b00, 2'b00, 16'hFFFF, 16'h5A5A, 2'b00},
        {2'b00, 2'b10, 2'b01, 16'h0F0F, 16'h5A0F, 2'b10},
        {2'b10, 2'b00, 2'b00, 16'hC3C3, 16'h5AC3, 2'b01},
        {2'b00, 2'b11, 2'b00, 16'h0000, 16'h5AC3, 2'b11},
        {2'b00, 2'b01, 2'b10, 16'h8001, 16'h80C3, 2'b01}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wrap_up();
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        failed++;
        $display("FAIL watchdog actual=hung expected=done");
        wrap_up();
    end

    initial begin
        b_in = 16'h7777;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 b_out", b_out, 16'h0000);
        chk("R1 a_out", a_out, 16'h0000);
        chk("R1 oe", {12'd0, a_oe, b_oe}, 16'h0000);
        chk("R1 contention", {14'd0, contention}, 16'h0000);

        // table walk: A-to-B patterns, B-to-A kept disabled
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            {en_ab_n, le_ab_n, oe_ab_n, a_in} = VEC[i][39:18];
            #1;
            chk($sformatf("R2 R3 R4 R7 R8 vec%0d b_out", i), b_out, VEC[i][17:2]);
            chk($sformatf("R5 vec%0d b_oe", i), {14'd0, b_oe}, {14'd0, VEC[i][1:0]});
            chk($sformatf("R10 vec%0d a_out", i), a_out, 16'h0000);
        end

        // B-to-A opens while A-to-B drives: contention on both bytes
        @(negedge clk);
        en_ab_n = 2'b00; le_ab_n = 2'b11; oe_ab_n = 2'b00;
        en_ba_n = 2'b00; le_ba_n = 2'b00; oe_ba_n = 2'b00; b_in = 16'h9876;
        #1;
        chk("R6 pass a_out", a_out, 16'h9876);
        chk("R6 a_oe", {14'd0, a_oe}, 16'h0003);
        chk("R10 b_out untouched", b_out, 16'h80C3);
        chk("R9 both bytes", {14'd0, contention}, 16'h0003);

        @(negedge clk);
        oe_ab_n = 2'b10;
        #1;
        chk("R9 byte0 only", {14'd0, contention}, 16'h0001);

        @(negedge clk);
        le_ba_n = 2'b11; b_in = 16'h1111;
        #1;
        chk("R6 hold a_out", a_out, 16'h9876);

        @(negedge clk);
        en_ba_n = 2'b01; le_ba_n = 2'b00; b_in = 16'h2222;
        #1;
        chk("R6 R7 mixed a_out", a_out, 16'h2276);
        chk("R6 a_oe byte1", {14'd0, a_oe}, 16'h0002);
        chk("R9 no overlap", {14'd0, contention}, 16'h0000);

        // reset mid-run clears both banks
        @(negedge clk);
        en_ab_n = 2'b11; en_ba_n = 2'b11; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 re-reset b_out", b_out, 16'h0000);
        chk("R1 re-reset a_out", a_out, 16'h0000);
        chk("R1 re-reset oe", {12'd0, a_oe, b_oe}, 16'h0000);

        wrap_up();
    end
endmodule